// File: doc/BRIEF.md
# DMA Channel Address/Count Engine

This block keeps the transfer state of a four-channel DMA controller. Each channel has a 16-bit memory address, a 14-bit remaining-transfer count and a 2-bit cycle type. The CPU interface loads these through write ports. The channel arbiter presents a grant index. Each time a transfer finishes on the granted channel, a cycle-done strobe steps the address up by one and the count down by one.

While a channel is granted, the engine shows that channel's address and cycle type. It raises a terminal-count flag on the final transfer of a block and a mark flag every 128 transfers. It also gives a per-channel pulse when a terminal count completes.

Two optional behaviours are selected by a mode word. In stop mode, a channel that finishes its block disables itself. In auto-load mode, channel 2 is refilled from channel 3 after its final transfer, and channel 3 is taken out of service. An update flag is raised for the one cycle in which the refill happens.

Top module: `dma_addr_count_engine`

## Requirements
- R1: While `rst_n` is low and after its release, every channel holds address 0, count 0 and cycle type verify, all channels are disabled, both modes are off and `update_flag` is low.
- R2: `ld_addr_wr` writes `ld_word` into the address of channel `ld_ch`. `ld_cnt_wr` writes `ld_word[13:0]` into its count and `ld_word[15:14]` into its cycle type. The cycle type codes are 00 verify, 01 write, 10 read and 11 illegal. `cur_addr` and `cur_cycle` always show the registers of channel `grant_ch`.
- R3: A transfer is active when `grant_valid` is high and the granted channel is serviceable. When an active transfer has `cycle_done` high, the channel's address rises by one (wrapping at 16 bits) and its count falls by one (wrapping at 14 bits) on that clock edge.
- R4: `tc` is high during an active transfer whose count is 0, so a programmed count of N-1 gives N transfers. In the same cycle that `cycle_done` completes such a transfer, `tc_pulse` shows the channel's bit.
- R5: `mark` is high during an active transfer whose count is nonzero and a multiple of 128.
- R6: A granted channel whose enable bit is clear is not serviceable. It raises neither `tc` nor `mark`, and `cycle_done` leaves its registers unchanged.
- R7: With stop mode on, completing a terminal-count transfer clears that channel's enable bit on the same edge. With stop mode off, the count wraps and the channel stays enabled.
- R8: With auto-load on, completing channel 2's terminal-count transfer raises `update_flag` for exactly the next cycle. At the end of that cycle, channel 2 takes channel 3's address, count and type. Stop mode does not disable channel 2 in this case.
- R9: With auto-load on, channel 3 is never serviceable, and channel 2 is not serviceable while `update_flag` is high.
- R10: A CPU load to a channel takes priority over a step or a refill of that channel in the same cycle.
- R11: `mode_wr` loads `mode_word`: bits 3:0 are the channel enables, bit 4 is stop mode and bit 5 is auto-load. A mode write wins over a same-cycle stop-mode disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_addr_wr | input | 1 | Load address of channel `ld_ch` |
| ld_cnt_wr | input | 1 | Load count and type of channel `ld_ch` |
| ld_ch | input | 2 | Channel addressed by a load |
| ld_word | input | 16 | Load data |
| mode_wr | input | 1 | Load the mode word |
| mode_word | input | 6 | Enables [3:0], stop mode [4], auto-load [5] |
| grant_valid | input | 1 | A channel is granted |
| grant_ch | input | 2 | Granted channel index |
| cycle_done | input | 1 | Current transfer completes this cycle |
| cur_addr | output | 16 | Address of the granted channel |
| cur_cycle | output | 2 | Cycle type of the granted channel |
| tc | output | 1 | Terminal-count transfer in progress |
| mark | output | 1 | Modulo-128 mark transfer in progress |
| tc_pulse | output | 4 | Per-channel terminal-count completion pulse |
| chan_en | output | 4 | Channel enable bits |
| update_flag | output | 1 | Channel 2 refill in progress |

## Verification
The checker watches several properties on every cycle:
- `tc_pulse` is one-hot or zero, and is only ever raised alongside `tc` and `cycle_done`.
- `mark` never coincides with `tc`.
- A channel that is off stays silent.
- A completed transfer steps the visible address by one when the same channel stays granted.
- A stop-mode terminal count clears that channel's enable bit.
- `update_flag` lasts one cycle and only follows a channel 2 terminal count under auto-load.

Other behaviours can only be shown by the bench's scenarios and its per-cycle reference model:
- the exact transfer count of a block and where the marks fall in a long block;
- the contents copied into channel 2;
- load priority over stepping;
- mode writes that collide with a stop.

// File: rtl/dmace_pkg.sv
package dmace_pkg;
  localparam int DMACE_NCH       = 4;
  localparam int DMACE_AW        = 16;
  localparam int DMACE_CW        = 14;
  localparam int DMACE_MARK_LOG2 = 7;

  typedef enum logic [1:0] {
    CYC_VERIFY = 2'b00,
    CYC_WRITE  = 2'b01,
    CYC_READ   = 2'b10,
    CYC_BAD    = 2'b11
  } cyc_e;
endpackage

// File: rtl/dmace_term_detect.sv
module dmace_term_detect #(
  parameter int CW        = 14,
  parameter int MARK_LOG2 = 7
) (
  input  logic [CW-1:0] cnt,
  output logic          is_term,
  output logic          is_mark
);
  function automatic logic at_term(input logic [CW-1:0] c);
    return c == '0;
  endfunction

  function automatic logic at_mark(input logic [CW-1:0] c);
    return (c != '0) && (c[MARK_LOG2-1:0] == '0);
  endfunction

  assign is_term = at_term(cnt);
  assign is_mark = at_mark(cnt);
endmodule

// File: rtl/dmace_channel.sv
module dmace_channel
  import dmace_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 14,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic [LW-1:0] ld_word,
  input  logic          step,
  input  logic          reload,
  input  logic [AW-1:0] src_addr,
  input  logic [CW-1:0] src_cnt,
  input  cyc_e          src_cyc,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output cyc_e          cyc_q
);
  function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_dec(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  // CPU load wins, then refill, then step
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (ld_addr) begin
      addr_q <= ld_word[AW-1:0];
    end else if (reload) begin
      addr_q <= src_addr;
    end else if (step) begin
      addr_q <= addr_inc(addr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cyc_q <= CYC_VERIFY;
    end else if (ld_cnt) begin
      cnt_q <= ld_word[CW-1:0];
      cyc_q <= cyc_e'(ld_word[CW+1:CW]);
    end else if (reload) begin
      cnt_q <= src_cnt;
      cyc_q <= src_cyc;
    end else if (step) begin
      cnt_q <= cnt_dec(cnt_q);
    end
  end
endmodule

// File: rtl/dmace_mode_ctl.sv
module dmace_mode_ctl #(
  parameter int NCH = 4,
  localparam int MW = NCH + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_wr,
  input  logic [MW-1:0]  mode_word,
  input  logic [NCH-1:0] stop_hit,
  input  logic           reload_start,
  output logic [NCH-1:0] chan_en,
  output logic           tc_stop,
  output logic           autoload,
  output logic           update_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_en  <= '0;
      tc_stop  <= 1'b0;
      autoload <= 1'b0;
    end else if (mode_wr) begin
      chan_en  <= mode_word[NCH-1:0];
      tc_stop  <= mode_word[NCH];
      autoload <= mode_word[NCH+1];
    end else begin
      chan_en  <= chan_en & ~stop_hit;
    end
  end

  // the refill occupies exactly the cycle after the triggering edge
  always_ff @(posedge clk) begin
    if (!rst_n) update_flag <= 1'b0;
    else        update_flag <= reload_start;
  end
endmodule

// File: rtl/dma_addr_count_engine.sv
module dma_addr_count_engine
  import dmace_pkg::*;
#(
  parameter int NCH        = DMACE_NCH,
  parameter int AW         = DMACE_AW,
  parameter int CW         = DMACE_CW,
  parameter int MARK_LOG2  = DMACE_MARK_LOG2,
  parameter int RELOAD_DST = 2,
  parameter int RELOAD_SRC = 3,
  localparam int CHW = $clog2(NCH),
  localparam int LW  = (AW > CW + 2) ? AW : CW + 2,
  localparam int MW  = NCH + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_addr_wr,
  input  logic           ld_cnt_wr,
  input  logic [CHW-1:0] ld_ch,
  input  logic [LW-1:0]  ld_word,
  input  logic           mode_wr,
  input  logic [MW-1:0]  mode_word,
  input  logic           grant_valid,
  input  logic [CHW-1:0] grant_ch,
  input  logic           cycle_done,
  output logic [AW-1:0]  cur_addr,
  output logic [1:0]     cur_cycle,
  output logic           tc,
  output logic           mark,
  output logic [NCH-1:0] tc_pulse,
  output logic [NCH-1:0] chan_en,
  output logic           update_flag
);
  localparam logic [CHW-1:0] DST_IDX = CHW'(RELOAD_DST);
  localparam logic [CHW-1:0] SRC_IDX = CHW'(RELOAD_SRC);

  logic [AW-1:0]  addr_q [NCH];
  logic [CW-1:0]  cnt_q  [NCH];
  cyc_e           cyc_q  [NCH];

  logic           tc_stop_q, autoload_q;
  logic           sel_term, sel_mark;
  logic           blocked, xfer_ok, xfer_fire, tc_fire, reload_start;
  logic [NCH-1:0] stop_hit;

  // serviceability of the granted channel
  assign blocked   = (autoload_q && grant_ch == SRC_IDX) ||
                     (update_flag && grant_ch == DST_IDX);
  assign xfer_ok   = grant_valid && chan_en[grant_ch] && !blocked;
  assign xfer_fire = xfer_ok && cycle_done;
  assign tc_fire   = xfer_fire && sel_term;
  assign reload_start = tc_fire && autoload_q && grant_ch == DST_IDX;

  dmace_term_detect #(.CW(CW), .MARK_LOG2(MARK_LOG2)) u_term (
    .cnt     (cnt_q[grant_ch]),
    .is_term (sel_term),
    .is_mark (sel_mark)
  );

  dmace_mode_ctl #(.NCH(NCH)) u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_wr      (mode_wr),
    .mode_word    (mode_word),
    .stop_hit     (stop_hit),
    .reload_start (reload_start),
    .chan_en      (chan_en),
    .tc_stop      (tc_stop_q),
    .autoload     (autoload_q),
    .update_flag  (update_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [CHW-1:0] IDX = CHW'(i);
    logic hit_here;
    assign hit_here    = grant_ch == IDX;
    assign tc_pulse[i] = tc_fire && hit_here;
    if (i == RELOAD_DST) begin : g_dst
      assign stop_hit[i] = tc_fire && hit_here && tc_stop_q && !autoload_q;
    end else begin : g_plain
      assign stop_hit[i] = tc_fire && hit_here && tc_stop_q;
    end

    dmace_channel #(.AW(AW), .CW(CW), .LW(LW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_addr  (ld_addr_wr && ld_ch == IDX),
      .ld_cnt   (ld_cnt_wr && ld_ch == IDX),
      .ld_word  (ld_word),
      .step     (xfer_fire && hit_here),
      .reload   ((i == RELOAD_DST) && update_flag),
      .src_addr (addr_q[RELOAD_SRC]),
      .src_cnt  (cnt_q[RELOAD_SRC]),
      .src_cyc  (cyc_q[RELOAD_SRC]),
      .addr_q   (addr_q[i]),
      .cnt_q    (cnt_q[i]),
      .cyc_q    (cyc_q[i])
    );
  end

  assign cur_addr  = addr_q[grant_ch];
  assign cur_cycle = cyc_q[grant_ch];
  assign tc        = xfer_ok && sel_term;
  assign mark      = xfer_ok && sel_mark;
endmodule

// File: rtl/dmace_checker.sv
module dmace_checker #(
  parameter int NCH        = 4,
  parameter int AW         = 16,
  parameter int RELOAD_DST = 2,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CHW-1:0] grant_ch,
  input logic           cycle_done,
  input logic           mode_wr,
  input logic           ld_addr_wr,
  input logic [CHW-1:0] ld_ch,
  input logic [AW-1:0]  cur_addr,
  input logic           tc,
  input logic           mark,
  input logic [NCH-1:0] tc_pulse,
  input logic [NCH-1:0] chan_en,
  input logic           update_flag,
  input logic           xfer_fire,
  input logic           tc_fire,
  input logic           tc_stop_q,
  input logic           autoload_q
);
  localparam logic [CHW-1:0] DST_IDX = CHW'(RELOAD_DST);

  logic           prev_step;
  logic [CHW-1:0] prev_ch;
  logic [AW-1:0]  prev_addr;
  logic [NCH-1:0] stop_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_step <= 1'b0;
      prev_ch   <= '0;
      prev_addr <= '0;
    end else begin
      prev_step <= xfer_fire && !(ld_addr_wr && ld_ch == grant_ch);
      prev_ch   <= grant_ch;
      prev_addr <= cur_addr;
    end
  end

  assign stop_mask = (tc_stop_q && !mode_wr &&
                      !(autoload_q && grant_ch == DST_IDX)) ? tc_pulse : '0;

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_pulse)); // R4
  AST_PULSE_WITH_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_pulse) |-> (tc && cycle_done)); // R4
  AST_MARK_NOT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> !tc); // R5
  AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en[grant_ch] |-> (!tc && !mark && !xfer_fire)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_step && grant_ch == prev_ch) |-> cur_addr == prev_addr + AW'(1)); // R3
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|stop_mask) |=> ((chan_en & $past(stop_mask)) == '0)); // R7
  AST_UPDATE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    update_flag |=> !update_flag); // R8
  AST_UPDATE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(update_flag) |-> $past(tc_fire && autoload_q && grant_ch == DST_IDX)); // R8
endmodule

bind dma_addr_count_engine dmace_checker #(
  .NCH(NCH), .AW(AW), .RELOAD_DST(RELOAD_DST)
) u_dmace_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .grant_ch    (grant_ch),
  .cycle_done  (cycle_done),
  .mode_wr     (mode_wr),
  .ld_addr_wr  (ld_addr_wr),
  .ld_ch       (ld_ch),
  .cur_addr    (cur_addr),
  .tc          (tc),
  .mark        (mark),
  .tc_pulse    (tc_pulse),
  .chan_en     (chan_en),
  .update_flag (update_flag),
  .xfer_fire   (xfer_fire),
  .tc_fire     (tc_fire),
  .tc_stop_q   (tc_stop_q),
  .autoload_q  (autoload_q)
);

// File: tb/dma_addr_count_engine_test.sv
`timescale 1ns/1ps
module dma_addr_count_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_addr_wr = 0, ld_cnt_wr = 0, mode_wr = 0;
  logic [1:0]  ld_ch = 0, grant_ch = 0;
  logic [15:0] ld_word = 0;
  logic [5:0]  mode_word = 0;
  logic        grant_valid = 0, cycle_done = 0;
  logic [15:0] cur_addr;
  logic [1:0]  cur_cycle;
  logic        tc, mark, update_flag;
  logic [3:0]  tc_pulse, chan_en;

  int checks = 0, failures = 0;
  string scen = "R1";

  // reference state
  int m_addr[4], m_cnt[4], m_typ[4];
  int m_en = 0, m_upd = 0;
  bit m_stop = 0, m_auto = 0;

  always #2.5 clk = ~clk;

  dma_addr_count_engine uut (
    .clk(clk), .rst_n(rst_n), .ld_addr_wr(ld_addr_wr), .ld_cnt_wr(ld_cnt_wr),
    .ld_ch(ld_ch), .ld_word(ld_word), .mode_wr(mode_wr), .mode_word(mode_word),
    .grant_valid(grant_valid), .grant_ch(grant_ch), .cycle_done(cycle_done),
    .cur_addr(cur_addr), .cur_cycle(cur_cycle), .tc(tc), .mark(mark),
    .tc_pulse(tc_pulse), .chan_en(chan_en), .update_flag(update_flag)
  );

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", scen, what, act, exp, $time);
    end
  endtask

  function automatic bit serviceable(input int g);
    if (!grant_valid || !m_en[g]) return 0;
    if (m_auto && g == 3) return 0;
    if (m_upd != 0 && g == 2) return 0;
    return 1;
  endfunction

  task automatic compare();
    int g = int'(grant_ch);
    bit act = serviceable(g);
    bit etc = act && m_cnt[g] == 0;
    bit emk = act && m_cnt[g] != 0 && (m_cnt[g] % 128) == 0;
    check("cur_addr R2/R3", int'(cur_addr), m_addr[g]);
    check("cur_cycle R2", int'(cur_cycle), m_typ[g]);
    check("tc R4", int'(tc), int'(etc));
    check("mark R5", int'(mark), int'(emk));
    check("tc_pulse R4", int'(tc_pulse), (etc && cycle_done) ? (1 << g) : 0);
    check("chan_en R7/R11", int'(chan_en), m_en);
    check("update_flag R8", int'(update_flag), m_upd);
  endtask

  task automatic model_update();
    int g = int'(grant_ch);
    int sa = m_addr[3], sc = m_cnt[3], st = m_typ[3];
    bit act = serviceable(g);
    int nupd = (act && cycle_done && m_cnt[g] == 0 && m_auto && g == 2) ? 1 : 0;
    if (act && cycle_done) begin
      if (m_cnt[g] == 0 && m_stop && !(m_auto && g == 2)) m_en[g] = 0;
      m_addr[g] = (m_addr[g] + 1) & 16'hFFFF;
      m_cnt[g]  = (m_cnt[g] + 16383) & 14'h3FFF;
    end
    if (m_upd != 0) begin m_addr[2] = sa; m_cnt[2] = sc; m_typ[2] = st; end
    if (ld_addr_wr) m_addr[ld_ch] = int'(ld_word);
    if (ld_cnt_wr) begin m_cnt[ld_ch] = int'(ld_word[13:0]); m_typ[ld_ch] = int'(ld_word[15:14]); end
    if (mode_wr) begin m_en = int'(mode_word[3:0]); m_stop = mode_word[4]; m_auto = mode_word[5]; end
    m_upd = nupd;
  endtask

  task automatic cyc(input bit gv, input int gch, input bit done,
                     input bit la = 0, input bit lc = 0, input int lch = 0,
                     input int lw = 0, input bit mw = 0, input int mword = 0);
    grant_valid = gv; grant_ch = 2'(gch); cycle_done = done;
    ld_addr_wr = la; ld_cnt_wr = lc; ld_ch = 2'(lch); ld_word = 16'(lw);
    mode_wr = mw; mode_word = 6'(mword);
    #1 compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic load(input int ch, input int a, input int cw);
    cyc(0, ch, 0, 1, 1, ch, a);
    cyc(0, ch, 0, 0, 1, ch, cw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog R1 actual=hung expected=finish");
    checks++; failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit [15:0] lf = 16'hACE1;
    for (int i = 0; i < 4; i++) begin m_addr[i] = 0; m_cnt[i] = 0; m_typ[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    scen = "R1 reset";
    compare();
    rst_n = 1'b1;
    cyc(0, 0, 0);
    cyc(1, 1, 1);

    scen = "R2 load and cycle type";
    load(0, 16'h1234, 16'h8003);   // read, 4 transfers
    load(1, 16'hFFFE, 16'h4001);   // write, 2 transfers
    load(2, 16'h0100, 16'h0000);
    load(3, 16'h7000, 16'hC002);   // illegal code shown as-is
    for (int c = 0; c < 4; c++) cyc(0, c, 0);

    scen = "R3 R4 step and terminal count, no stop";
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'h01);
    for (int k = 0; k < 6; k++) cyc(1, 0, 1);
    cyc(1, 0, 0);

    scen = "R7 stop mode with address wrap";
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'h1F);
    for (int k = 0; k < 4; k++) cyc(1, 1, 1);
    cyc(1, 1, 0);

    scen = "R6 disabled channel ignored";
    for (int k = 0; k < 3; k++) cyc(1, 1, 1);

    scen = "R5 mark spacing";
    load(0, 16'h2000, 16'h012C);   // verify, 301 transfers
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'h01);
    for (int k = 0; k < 302; k++) cyc(1, 0, 1);

    scen = "R8 R9 auto-load refill";
    load(3, 16'h8000, 16'h4005);
    load(2, 16'h0100, 16'h8001);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'h3C);
    for (int k = 0; k < 3; k++) cyc(1, 3, 1);
    for (int k = 0; k < 10; k++) cyc(1, 2, 1);
    cyc(1, 2, 0);

    scen = "R10 load beats step";
    load(0, 16'h0500, 16'h4002);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'h01);
    cyc(1, 0, 1, 1, 0, 0, 16'hABCD);
    cyc(1, 0, 1, 0, 1, 0, 16'h8000);
    cyc(1, 0, 1);
    cyc(1, 0, 0);

    scen = "R11 mode write beats stop";
    load(1, 16'h0010, 16'h0000);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'h12);
    cyc(1, 1, 1, 0, 0, 0, 0, 1, 6'h13);
    cyc(1, 1, 0);

    scen = "R3 R4 R5 mixed traffic";
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'h0F);
    for (int c = 0; c < 4; c++) load(c, c * 16'h1000, 16'h0084 + c);
    for (int k = 0; k < 600; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[9:5] == 5'd3)
        cyc(0, 0, 0, 0, 0, 0, 0, 1, {lf[1:0] == 2'b00, lf[2], 4'hF});
      else if (lf[9:5] == 5'd7)
        cyc(lf[0], int'(lf[2:1]), 0, 0, 1, int'(lf[4:3]), {lf[15:14], 6'd0, lf[13:6]});
      else
        cyc(lf[15] | lf[0], int'(lf[3:2]), lf[4] | lf[1]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule